// File: doc/BRIEF.md
# Two-Phase Serial Frame Receiver

This block turns a synchronous serial bit stream into parallel words. A frame-sync pulse marks the start of each frame. Serial data is taken only on clock cycles where the receive sample enable is high; that enable stands for the falling edge of the receive bit clock. A frame holds one or two phases. Each phase has its own word length and its own word count. Each word is shifted in most significant bit first. When a word is complete it appears right-justified and zero-filled on a 32-bit output, together with a one-cycle valid pulse.

The start of the data can lag the frame start by zero, one or two bit samples. The two-sample setting drops a framing bit that sits between the sync and the data. A sync pulse can arrive while a frame is still in progress. The block then does one of two things, chosen by a control input: it aborts and restarts, raising a sticky error flag, or it ignores the pulse. Clock generation, sync generation, slot selection and companding belong to other blocks.

Top module: `serial_frame_rx`

## Requirements
- R1: While rst_n is low at a clock edge, word_valid and sync_err are 0 after that edge. After rst_n returns high, the receiver waits for a frame sync and produces no word from serial data alone.
- R2: The internal sync is fsync when fs_active_low is 0 and the inverse of fsync when it is 1. A frame starts on a sample where the internal sync is high and it was low on the previous sample. A sync held high for several samples starts only one frame.
- R3: With dual_phase = 0, a frame has wcnt1+1 words of length wlen1, and wlen2 and wcnt2 have no effect.
- R4: With dual_phase = 1, a frame has wcnt1+1 words of length wlen1, followed by wcnt2+1 words of length wlen2.
- R5: Length codes 0, 1, 2, 3, 4 and 5 select 8, 12, 16, 20, 24 and 32 bits, and codes 6 and 7 also select 32 bits. Bits arrive MSB first. word_out holds the word in its low bits, and the bits above are zero.
- R6: The count fields are 7 bits and hold the number of words minus one, so a value of 127 gives 128 words in a phase.
- R7: With delay = 0, the sample that detects the frame start is the first data bit. With delay = 1, the first data bit is the next sample.
- R8: With delay = 2 (or 3), the sample that follows the frame-start sample is a framing bit and is discarded. Data begins on the sample after it.
- R9: With ignore_fs = 0, a frame start inside a frame discards the partial word and sets sync_err. A new frame then begins, with the programmed delay counted from that sample.
- R10: With ignore_fs = 1, a frame start inside a frame has no effect on the words received and does not set sync_err.
- R11: After the last word of a frame the receiver is idle, and serial data that arrives without a new frame start produces no word.
- R12: sync_err stays at 1 until err_clr is high at a clock edge, and that edge clears it.
- R13: Only cycles with bit_en high advance the receiver. word_valid is a one-cycle pulse in the clock cycle after the edge that sampled the word's last bit.
- R14: A reset pulse in the middle of a word discards that word. A later frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low receiver reset |
| bit_en | input | 1 | Receive sample enable, one per bit |
| sdata | input | 1 | Serial data |
| fsync | input | 1 | Frame-sync input |
| fs_active_low | input | 1 | 1 = fsync is active low |
| dual_phase | input | 1 | 1 = two-phase frame |
| wlen1 | input | 3 | Phase-1 word length code |
| wlen2 | input | 3 | Phase-2 word length code |
| wcnt1 | input | 7 | Phase-1 word count minus one |
| wcnt2 | input | 7 | Phase-2 word count minus one |
| delay | input | 2 | Data delay in bit samples (0, 1, 2; 3 acts as 2) |
| ignore_fs | input | 1 | 1 = ignore frame syncs that arrive mid-frame |
| err_clr | input | 1 | Clears sync_err |
| word_out | output | 32 | Received word, right-justified |
| word_valid | output | 1 | One-cycle pulse, word_out is new |
| sync_err | output | 1 | Sticky mid-frame sync error |

## Verification
Several properties are checked by embedded assertions on every clock cycle:
- A valid pulse appears only after an enabled sample.
- The error flag is sticky until it is cleared.
- The flag rises only after an active sync sample with ignore off.
- The receiver state holds still between enables.
- The bit counter stays below the active word length.

Other behaviour can only be shown by the bench's directed scenarios with known expected words. These scenarios cover word assembly and phase sequencing, the length codes, the three delays with framing-bit removal, the abort and ignore policies, edge detection of a held sync, and the 128-word boundary.

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sdata,
  input  logic             fsync,
  input  logic             fs_active_low,
  input  logic             dual_phase,
  input  logic [2:0]       wlen1,
  input  logic [2:0]       wlen2,
  input  logic [CNT_W-1:0] wcnt1,
  input  logic [CNT_W-1:0] wcnt2,
  input  logic [1:0]       delay,
  input  logic             ignore_fs,
  input  logic             err_clr,
  output logic [31:0]      word_out,
  output logic             word_valid,
  output logic             sync_err
);
  localparam int BC_W = 6;

  typedef enum logic [1:0] {IDLE, SKIP, DATA} st_t;

  st_t              st;
  logic             fs_prev;
  logic             ph;
  logic [31:0]      sh;
  logic [BC_W-1:0]  bcnt;
  logic [CNT_W-1:0] wcnt;

  function automatic logic [BC_W-1:0] len_of(input logic [2:0] c);
    case (c)
      3'd0:    len_of = 6'd8;
      3'd1:    len_of = 6'd12;
      3'd2:    len_of = 6'd16;
      3'd3:    len_of = 6'd20;
      3'd4:    len_of = 6'd24;
      default: len_of = 6'd32;
    endcase
  endfunction

  wire              fs_int   = fsync ^ fs_active_low;
  wire              start    = bit_en && fs_int && !fs_prev;
  wire              busy     = (st != IDLE);
  wire              restart  = start && (!busy || !ignore_fs);
  wire [BC_W-1:0]   cur_len  = len_of(ph ? wlen2 : wlen1);
  wire [CNT_W-1:0]  cur_max  = ph ? wcnt2 : wcnt1;
  wire [31:0]       sh_nx    = {sh[30:0], sdata};
  wire              bit_last = (bcnt + 6'd1 == cur_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      fs_prev    <= 1'b0;
      ph         <= 1'b0;
      sh         <= '0;
      bcnt       <= '0;
      wcnt       <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
      sync_err   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (bit_en) fs_prev <= fs_int;
      if (err_clr) sync_err <= 1'b0;
      if (start && busy && !ignore_fs) sync_err <= 1'b1;
      if (restart) begin
        ph   <= 1'b0;
        wcnt <= '0;
        if (delay == 2'd0) begin
          sh   <= {31'b0, sdata};
          bcnt <= 6'd1;
        end else begin
          sh   <= '0;
          bcnt <= '0;
        end
        st <= delay[1] ? SKIP : DATA;
      end else if (bit_en) begin
        case (st)
          SKIP: st <= DATA;
          DATA: begin
            if (bit_last) begin
              word_out   <= sh_nx;
              word_valid <= 1'b1;
              sh         <= '0;
              bcnt       <= '0;
              if (wcnt == cur_max) begin
                wcnt <= '0;
                if (!ph && dual_phase) ph <= 1'b1;
                else st <= IDLE;
              end else begin
                wcnt <= wcnt + 1'b1;
              end
            end else begin
              sh   <= sh_nx;
              bcnt <= bcnt + 6'd1;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  p_valid_after_sample_r13: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_en));

  p_hold_between_samples_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(st) && $stable(bcnt) && $stable(wcnt));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err && !err_clr |=> sync_err);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> $past(bit_en && !ignore_fs && (fsync ^ fs_active_low)));

  p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == DATA |-> bcnt < cur_len);

endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, sdata = 1'b0, fsync = 1'b0, fs_active_low = 1'b0;
  logic        dual_phase = 1'b0, ignore_fs = 1'b0, err_clr = 1'b0;
  logic [2:0]  wlen1 = '0, wlen2 = '0;
  logic [6:0]  wcnt1 = '0, wcnt2 = '0;
  logic [1:0]  delay = '0;
  logic [31:0] word_out;
  logic        word_valid, sync_err;

  int checks = 0, fails = 0, cyc = 0, ncap = 0;
  logic [31:0] cap [0:255];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdata(sdata), .fsync(fsync),
    .fs_active_low(fs_active_low), .dual_phase(dual_phase), .wlen1(wlen1),
    .wlen2(wlen2), .wcnt1(wcnt1), .wcnt2(wcnt2), .delay(delay),
    .ignore_fs(ignore_fs), .err_clr(err_clr), .word_out(word_out),
    .word_valid(word_valid), .sync_err(sync_err)
  );

  always @(negedge clk) if (word_valid && ncap < 256) begin
    cap[ncap] = word_out;
    ncap++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: act %0d cycles exp done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic d, input logic f);
    @(negedge clk);
    sdata = d; fsync = f ^ fs_active_low; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; fsync = fs_active_low;
  endtask

  task automatic send(input logic [31:0] v, input int n, input logic fs_first);
    for (int i = n - 1; i >= 0; i--) sbit(v[i], fs_first && (i == n - 1));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sbit(1'b0, 1'b0);
  endtask

  task automatic clr_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(word_valid == 1'b0, "R1 valid in reset", word_valid, 0);
    chk(sync_err == 1'b0, "R1 err in reset", sync_err, 0);
    rst_n = 1'b1;
    ncap = 0;
    send(32'hA5, 8, 1'b0); send(32'h3C, 8, 1'b0);
    chk(ncap == 0, "R1 no word without sync", ncap, 0);
  endtask

  task automatic t_single();
    dual_phase = 0; wlen1 = 0; wcnt1 = 1; wlen2 = 2; wcnt2 = 3; delay = 1; ncap = 0;
    sbit(1'b1, 1'b1);
    send(32'hA5, 8, 1'b0); send(32'h3C, 8, 1'b0);
    idle(4);
    chk(ncap == 2, "R3 word count", ncap, 2);
    chk(cap[0] == 32'hA5, "R7 first word delay1", cap[0], 32'hA5);
    chk(cap[1] == 32'h3C, "R3 second word", cap[1], 32'h3C);
    send(32'hFF, 8, 1'b0);
    chk(ncap == 2, "R11 idle after frame", ncap, 2);
  endtask

  task automatic t_dual_low();
    @(negedge clk); fs_active_low = 1'b1; fsync = 1'b1;
    dual_phase = 1; wlen1 = 1; wcnt1 = 0; wlen2 = 0; wcnt2 = 1; delay = 0; ncap = 0;
    send(32'hABC, 12, 1'b1); send(32'h12, 8, 1'b0); send(32'h34, 8, 1'b0);
    idle(4);
    chk(ncap == 3, "R4 dual count", ncap, 3);
    chk(cap[0] == 32'hABC, "R2 active-low start, R7 delay0", cap[0], 32'hABC);
    chk(cap[1] == 32'h12, "R4 phase2 word1", cap[1], 32'h12);
    chk(cap[2] == 32'h34, "R4 phase2 word2", cap[2], 32'h34);
    @(negedge clk); fs_active_low = 1'b0; fsync = 1'b0;
  endtask

  task automatic t_lengths();
    dual_phase = 1; wlen1 = 2; wcnt1 = 0; wlen2 = 5; wcnt2 = 0; delay = 1; ncap = 0;
    sbit(1'b0, 1'b1); send(32'hBEEF, 16, 1'b0); send(32'hC0FFEE11, 32, 1'b0);
    idle(2);
    wlen1 = 3; wlen2 = 4;
    sbit(1'b1, 1'b1); send(32'hFABCDE, 20, 1'b0); send(32'hFF123456, 24, 1'b0);
    idle(2);
    dual_phase = 0; wlen1 = 7;
    sbit(1'b0, 1'b1); send(32'h89ABCDEF, 32, 1'b0);
    idle(2);
    chk(ncap == 5, "R5 word count", ncap, 5);
    chk(cap[0] == 32'hBEEF, "R5 16-bit", cap[0], 32'hBEEF);
    chk(cap[1] == 32'hC0FFEE11, "R5 32-bit", cap[1], 32'hC0FFEE11);
    chk(cap[2] == 32'hABCDE, "R5 20-bit zero-filled", cap[2], 32'hABCDE);
    chk(cap[3] == 32'h123456, "R5 24-bit zero-filled", cap[3], 32'h123456);
    chk(cap[4] == 32'h89ABCDEF, "R5 code 7 as 32-bit", cap[4], 32'h89ABCDEF);
  endtask

  task automatic t_delay2();
    dual_phase = 0; wlen1 = 0; wcnt1 = 0; delay = 2; ncap = 0;
    sbit(1'b0, 1'b1); sbit(1'b1, 1'b0); send(32'h5A, 8, 1'b0);
    idle(2);
    delay = 3;
    sbit(1'b1, 1'b1); sbit(1'b1, 1'b0); send(32'h0F, 8, 1'b0);
    idle(2);
    chk(ncap == 2, "R8 count", ncap, 2);
    chk(cap[0] == 32'h5A, "R8 framing bit dropped", cap[0], 32'h5A);
    chk(cap[1] == 32'h0F, "R8 code 3 as 2", cap[1], 32'h0F);
  endtask

  task automatic t_abort();
    clr_err();
    dual_phase = 0; wlen1 = 0; wcnt1 = 1; delay = 1; ignore_fs = 0; ncap = 0;
    sbit(1'b0, 1'b1); send(32'hF, 4, 1'b0);
    sbit(1'b1, 1'b1); send(32'h11, 8, 1'b0); send(32'h22, 8, 1'b0);
    idle(4);
    chk(ncap == 2, "R9 words after restart", ncap, 2);
    chk(cap[0] == 32'h11, "R9 first word after abort", cap[0], 32'h11);
    chk(cap[1] == 32'h22, "R9 second word", cap[1], 32'h22);
    chk(sync_err == 1'b1, "R9 error set", sync_err, 1);
    idle(5);
    chk(sync_err == 1'b1, "R12 error sticky", sync_err, 1);
    clr_err();
    chk(sync_err == 1'b0, "R12 error cleared", sync_err, 0);
  endtask

  task automatic t_ignore();
    dual_phase = 0; wlen1 = 0; wcnt1 = 1; delay = 1; ignore_fs = 1; ncap = 0;
    sbit(1'b0, 1'b1); send(32'hA, 4, 1'b0); send(32'h5, 4, 1'b1); send(32'hC3, 8, 1'b0);
    idle(4);
    chk(ncap == 2 && cap[0] == 32'hA5, "R10 word unaffected", cap[0], 32'hA5);
    chk(cap[1] == 32'hC3, "R10 frame continues", cap[1], 32'hC3);
    chk(sync_err == 1'b0, "R10 no error", sync_err, 0);
    ignore_fs = 0; wcnt1 = 0; ncap = 0;
    sbit(1'b0, 1'b1);
    for (int i = 7; i >= 0; i--) sbit(i[0] ^ 1'b1, i >= 6);
    idle(2);
    chk(sync_err == 1'b0, "R2 held sync single start", sync_err, 0);
    chk(ncap == 1 && cap[0] == 32'h55, "R2 held sync word", cap[0], 32'h55);
  endtask

  task automatic t_max();
    dual_phase = 0; wlen1 = 0; wcnt1 = 127; delay = 1; ncap = 0;
    sbit(1'b0, 1'b1);
    for (int i = 0; i < 128; i++) send(i, 8, 1'b0);
    idle(2);
    chk(ncap == 128, "R6 128 words", ncap, 128);
    chk(cap[0] == 32'h00 && cap[127] == 32'h7F, "R6 last word", cap[127], 32'h7F);
    send(32'h99, 8, 1'b0);
    chk(ncap == 128, "R11 idle after 128", ncap, 128);
  endtask

  task automatic t_timing();
    dual_phase = 0; wlen1 = 0; wcnt1 = 0; delay = 0; ncap = 0;
    send(32'h4B, 7, 1'b1);
    @(negedge clk); sdata = 1'b0; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    chk(word_valid == 1'b1, "R13 valid after last bit", word_valid, 1);
    chk(word_out == 32'h96, "R13 word value", word_out, 32'h96);
    @(negedge clk);
    chk(word_valid == 1'b0, "R13 one-cycle pulse", word_valid, 0);
  endtask

  task automatic t_rst_mid();
    dual_phase = 0; wlen1 = 0; wcnt1 = 1; delay = 1; ncap = 0;
    sbit(1'b0, 1'b1); send(32'h1F, 5, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    send(32'h7, 3, 1'b0);
    idle(2);
    chk(ncap == 0, "R14 partial word dropped", ncap, 0);
    sbit(1'b0, 1'b1); send(32'h77, 8, 1'b0);
    idle(2);
    chk(ncap == 1 && cap[0] == 32'h77, "R14 new frame after reset", cap[0], 32'h77);
  endtask

  initial begin
    t_reset();
    t_single();
    t_dual_low();
    t_lengths();
    t_delay2();
    t_abort();
    t_ignore();
    t_max();
    t_timing();
    t_rst_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule